// File: doc/BRIEF.md
# Virtual Counter Read Unit

This block keeps a free-running 64-bit physical time count and a 64-bit virtual offset, and answers software reads of the virtual count. Each read carries the privilege level of the requester (0 to 3) together with the execution-state and control context that governs access. The block either returns a 64-bit value split into two 32-bit words, or reports that the access must not complete. In that case it names the kind of fault, the privilege level that takes it and a syndrome code.

Whether a read is allowed is decided by a prioritised chain of checks. The inputs to that chain are the requester's level, whether levels 1 and 2 run in the narrow (32-bit) or the wide (64-bit) state, whether a hypervisor level exists and is enabled, the host-mode bit pair, and per-level enable and trap bits. Allowed reads return the physical count minus the offset or the bare physical count, according to the same context. Requests and responses use valid/ready handshakes with a single request in flight. The count that a response reports is captured in the cycle its request is accepted.

Top module: `vcnt_read_unit`

## Requirements
- R1: A returned virtual value equals the physical count minus the offset, modulo 2^64. It wraps when the offset exceeds the count.
- R2: The upper 32 bits of a returned value appear on `resp_hi` and the lower 32 bits on `resp_lo`. On any non-data response both words are zero.
- R3: At level 0 with level 1 wide, host mode inactive and `l1_en_wide` clear, the response is a trap (`resp_kind`=1) with syndrome 0x04. The target is level 2 if the hypervisor is enabled, wide and `trap_gen` is set; otherwise the target is level 1. Encoding of `resp_kind`: 0 data, 1 trap, 2 hypervisor trap, 3 undefined.
- R4: At level 0 with level 1 narrow and `l1_en_narrow` clear, there are three outcomes. If the hypervisor is enabled, wide and `trap_gen` is set, the response is a trap (kind 1) to level 2 with syndrome 0x04. If it is enabled, narrow and `trap_gen` is set, the response is a hypervisor trap (kind 2, target 2, syndrome 0x00). Otherwise the response is undefined (kind 3, target 0, syndrome 0).
- R5: Host mode is active when the hypervisor is enabled and wide and both `host_e2h` and `trap_gen` are set. In host mode, a level-0 read with `l2_host_en` clear traps (kind 1) to level 2 with syndrome 0x04.
- R6: A read at level 0 (after R3 to R5) or at level 1 traps (kind 1) to level 2 with syndrome 0x04 when the hypervisor is enabled and wide and `l2_trap_lo` is set. At level 0 this also requires host mode to be inactive.
- R7: An allowed read at level 0 or 1 returns the count minus the offset if a hypervisor level exists. It returns the raw count if none exists, or for a level-0 read in host mode.
- R8: Reads at level 2 never fault and subtract the offset. Reads at level 3 never fault and subtract the offset only when a hypervisor level exists.
- R9: `req_ready` is low while a response is pending. A response appears one cycle after its request is accepted and stays valid and unchanged until `resp_ready`. Responses come back in request order.
- R10: The reported value uses the count and offset held in the acceptance cycle.
- R11: After reset the count and the offset are zero. The count rises by one on each clock with `cnt_en` high and holds otherwise. `off_wr` loads `off_data` into the offset on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Count enable for the physical counter |
| off_wr | input | 1 | Offset load strobe |
| off_data | input | 64 | New offset value |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Request can be accepted |
| req_level | input | 2 | Privilege level of the requester |
| l1_narrow | input | 1 | Level 1 runs in 32-bit state |
| l2_narrow | input | 1 | Level 2 runs in 32-bit state |
| hyp_present | input | 1 | Level 2 is implemented |
| hyp_enabled | input | 1 | Level 2 is enabled |
| host_e2h | input | 1 | Host-mode hosting bit |
| trap_gen | input | 1 | General trap-to-hypervisor bit |
| l1_en_wide | input | 1 | Level-0 access enable set by a wide level 1 |
| l1_en_narrow | input | 1 | Level-0 access enable set by a narrow level 1 |
| l2_host_en | input | 1 | Level-0 access enable under host mode |
| l2_trap_lo | input | 1 | Level 2 traps lower-level reads |
| resp_valid | output | 1 | Response valid |
| resp_ready | input | 1 | Response consumed |
| resp_hi | output | 32 | Upper word of the value |
| resp_lo | output | 32 | Lower word of the value |
| resp_kind | output | 2 | 0 data, 1 trap, 2 hypervisor trap, 3 undefined |
| resp_target | output | 2 | Level that takes the fault |
| resp_syndrome | output | 8 | Syndrome code |

## Verification
A vector table exercises every branch of the decision chain. For level 0 it varies the state of level 1 and 2, the host-mode pair and the enable and trap bits, so that each trap target and kind is separated from its neighbours. Allowed reads run with and without a hypervisor level, in and out of host mode, and at levels 2 and 3, so that the subtracting and raw paths are told apart. The offset exceeds the count, so the results wrap and show a nonzero upper word. Directed cases cover reset values, offset loading, a held counter, back-pressure on the response, and ordered back-to-back reads.

// File: rtl/vcnt_pkg.sv
package vcnt_pkg;
   typedef enum logic [1:0] {
      VK_DATA  = 2'd0,
      VK_TRAP  = 2'd1,
      VK_HYP   = 2'd2,
      VK_UNDEF = 2'd3
   } vcnt_kind_e;
endpackage

// File: rtl/vcnt_time_base.sv
module vcnt_time_base #(
   parameter int CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_en,
   input  logic             off_wr,
   input  logic [CNT_W-1:0] off_data,
   output logic [CNT_W-1:0] phys_q,
   output logic [CNT_W-1:0] off_q
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   if (CNT_W < 2) begin : g_bad_width
      $error("vcnt_time_base: CNT_W too small");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phys_q <= '0;
         off_q  <= '0;
      end else begin
         if (cnt_en) phys_q <= phys_q + ONE;
         if (off_wr) off_q  <= off_data;
      end
   end

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_en |=> phys_q == $past(phys_q) + ONE);   // R11
   AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_en |=> $stable(phys_q));                // R11
endmodule

// File: rtl/vcnt_access_policy.sv
module vcnt_access_policy
   import vcnt_pkg::*;
#(
   parameter int          SYN_W    = 8,
   parameter logic [7:0]  TRAP_SYN = 8'h04,
   parameter logic [7:0]  HYP_SYN  = 8'h00
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       level,
   input  logic             l1_narrow,
   input  logic             l2_narrow,
   input  logic             hyp_present,
   input  logic             hyp_enabled,
   input  logic             host_e2h,
   input  logic             trap_gen,
   input  logic             l1_en_wide,
   input  logic             l1_en_narrow,
   input  logic             l2_host_en,
   input  logic             l2_trap_lo,
   output vcnt_kind_e       kind,
   output logic [1:0]       target,
   output logic [SYN_W-1:0] syndrome,
   output logic             use_offset
);
   localparam logic [SYN_W-1:0] SYN_T = SYN_W'(TRAP_SYN);
   localparam logic [SYN_W-1:0] SYN_H = SYN_W'(HYP_SYN);

   if (SYN_W < 3) begin : g_bad_syn
      $error("vcnt_access_policy: SYN_W cannot hold the trap syndrome");
   end

   logic l2_on, l2_wide_on, l2_narrow_on, host_mode;

   assign l2_on        = hyp_present & hyp_enabled;
   assign l2_wide_on   = l2_on & ~l2_narrow;
   assign l2_narrow_on = l2_on &  l2_narrow;
   assign host_mode    = l2_wide_on & host_e2h & trap_gen;

   always_comb begin
      kind       = VK_DATA;
      target     = 2'd0;
      syndrome   = '0;
      use_offset = 1'b0;
      unique case (level)
         2'd0: begin
            if (!l1_narrow && !host_mode && !l1_en_wide) begin
               kind     = VK_TRAP;
               target   = (l2_wide_on && trap_gen) ? 2'd2 : 2'd1;
               syndrome = SYN_T;
            end else if (l1_narrow && !l1_en_narrow) begin
               if (l2_wide_on && trap_gen) begin
                  kind     = VK_TRAP;
                  target   = 2'd2;
                  syndrome = SYN_T;
               end else if (l2_narrow_on && trap_gen) begin
                  kind     = VK_HYP;
                  target   = 2'd2;
                  syndrome = SYN_H;
               end else begin
                  kind     = VK_UNDEF;
               end
            end else if (host_mode && !l2_host_en) begin
               kind     = VK_TRAP;
               target   = 2'd2;
               syndrome = SYN_T;
            end else if (l2_wide_on && !host_mode && l2_trap_lo) begin
               kind     = VK_TRAP;
               target   = 2'd2;
               syndrome = SYN_T;
            end else begin
               use_offset = hyp_present & ~host_mode;
            end
         end
         2'd1: begin
            if (l2_wide_on && l2_trap_lo) begin
               kind     = VK_TRAP;
               target   = 2'd2;
               syndrome = SYN_T;
            end else begin
               use_offset = hyp_present;
            end
         end
         2'd2: use_offset = 1'b1;
         default: use_offset = hyp_present;
      endcase
   end

   AST_HIGH_LEVELS_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      level[1] |-> kind == VK_DATA);                          // R8
   AST_UNDEF_ONLY_NARROW_L0: assert property (@(posedge clk) disable iff (!rst_n)
      kind == VK_UNDEF |-> (level == 2'd0 && l1_narrow));     // R4
   AST_HYP_TRAP_NEEDS_HYP: assert property (@(posedge clk) disable iff (!rst_n)
      kind == VK_HYP |-> (hyp_present && hyp_enabled && l2_narrow)); // R4
endmodule

// File: rtl/vcnt_resp_stage.sv
module vcnt_resp_stage
   import vcnt_pkg::*;
#(
   parameter int CNT_W = 64,
   parameter int SYN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  vcnt_kind_e       dec_kind,
   input  logic [1:0]       dec_target,
   input  logic [SYN_W-1:0] dec_syndrome,
   input  logic             dec_use_offset,
   input  logic [CNT_W-1:0] phys,
   input  logic [CNT_W-1:0] offset,
   output logic             resp_valid,
   input  logic             resp_ready,
   output logic [CNT_W-1:0] resp_data,
   output vcnt_kind_e       resp_kind,
   output logic [1:0]       resp_target,
   output logic [SYN_W-1:0] resp_syndrome
);
   logic             accept;
   logic [CNT_W-1:0] value_d;

   assign req_ready = ~resp_valid;
   assign accept    = req_valid & req_ready;

   always_comb begin
      if (dec_kind != VK_DATA)  value_d = '0;
      else if (dec_use_offset)  value_d = phys - offset;
      else                      value_d = phys;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         resp_valid    <= 1'b0;
         resp_data     <= '0;
         resp_kind     <= VK_DATA;
         resp_target   <= 2'd0;
         resp_syndrome <= '0;
      end else if (accept) begin
         resp_valid    <= 1'b1;
         resp_data     <= value_d;
         resp_kind     <= dec_kind;
         resp_target   <= dec_target;
         resp_syndrome <= dec_syndrome;
      end else if (resp_ready) begin
         resp_valid    <= 1'b0;
      end
   end

   AST_ACCEPT_GIVES_RESP: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> resp_valid);                                          // R9
   AST_SINGLE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> !req_ready);                                      // R9
   AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_data)
                                       && $stable(resp_kind)));        // R9
   AST_FAULT_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_kind != VK_DATA) |-> resp_data == '0);       // R2
endmodule

// File: rtl/vcnt_read_unit.sv
module vcnt_read_unit
   import vcnt_pkg::*;
#(
   parameter int         CNT_W    = 64,
   parameter int         WORD_W   = 32,
   parameter int         SYN_W    = 8,
   parameter logic [7:0] TRAP_SYN = 8'h04,
   parameter logic [7:0] HYP_SYN  = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_en,
   input  logic              off_wr,
   input  logic [CNT_W-1:0]  off_data,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_level,
   input  logic              l1_narrow,
   input  logic              l2_narrow,
   input  logic              hyp_present,
   input  logic              hyp_enabled,
   input  logic              host_e2h,
   input  logic              trap_gen,
   input  logic              l1_en_wide,
   input  logic              l1_en_narrow,
   input  logic              l2_host_en,
   input  logic              l2_trap_lo,
   output logic              resp_valid,
   input  logic              resp_ready,
   output logic [WORD_W-1:0] resp_hi,
   output logic [WORD_W-1:0] resp_lo,
   output logic [1:0]        resp_kind,
   output logic [1:0]        resp_target,
   output logic [SYN_W-1:0]  resp_syndrome
);
   localparam int N_WORDS = CNT_W / WORD_W;

   if (N_WORDS != 2 || CNT_W % WORD_W != 0) begin : g_bad_split
      $error("vcnt_read_unit: CNT_W must be exactly two words");
   end

   logic [CNT_W-1:0] phys_q, off_q, data_q;
   vcnt_kind_e       dec_kind, kind_q;
   logic [1:0]       dec_target;
   logic [SYN_W-1:0] dec_syndrome;
   logic             dec_use_offset;
   logic [WORD_W-1:0] words [N_WORDS];

   vcnt_time_base #(.CNT_W(CNT_W)) i_time (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .off_wr(off_wr),
      .off_data(off_data), .phys_q(phys_q), .off_q(off_q)
   );

   vcnt_access_policy #(.SYN_W(SYN_W), .TRAP_SYN(TRAP_SYN), .HYP_SYN(HYP_SYN)) i_policy (
      .clk(clk), .rst_n(rst_n), .level(req_level),
      .l1_narrow(l1_narrow), .l2_narrow(l2_narrow),
      .hyp_present(hyp_present), .hyp_enabled(hyp_enabled),
      .host_e2h(host_e2h), .trap_gen(trap_gen),
      .l1_en_wide(l1_en_wide), .l1_en_narrow(l1_en_narrow),
      .l2_host_en(l2_host_en), .l2_trap_lo(l2_trap_lo),
      .kind(dec_kind), .target(dec_target), .syndrome(dec_syndrome),
      .use_offset(dec_use_offset)
   );

   vcnt_resp_stage #(.CNT_W(CNT_W), .SYN_W(SYN_W)) i_resp (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .dec_kind(dec_kind), .dec_target(dec_target), .dec_syndrome(dec_syndrome),
      .dec_use_offset(dec_use_offset), .phys(phys_q), .offset(off_q),
      .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_data(data_q),
      .resp_kind(kind_q), .resp_target(resp_target), .resp_syndrome(resp_syndrome)
   );

   for (genvar w = 0; w < N_WORDS; w++) begin : g_split
      assign words[w] = data_q[w*WORD_W +: WORD_W];
   end

   assign resp_lo   = words[0];
   assign resp_hi   = words[N_WORDS-1];
   assign resp_kind = kind_q;
endmodule

// File: tb/test_vcnt_read_unit.sv
`timescale 1ns/1ps
module test_vcnt_read_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cnt_en = 1'b0, off_wr = 1'b0;
   logic [63:0] off_data = '0;
   logic        req_valid = 1'b0, req_ready;
   logic [1:0]  req_level = '0;
   logic        l1_narrow = 0, l2_narrow = 0, hyp_present = 0, hyp_enabled = 0;
   logic        host_e2h = 0, trap_gen = 0, l1_en_wide = 0, l1_en_narrow = 0;
   logic        l2_host_en = 0, l2_trap_lo = 0;
   logic        resp_valid, resp_ready = 1'b1;
   logic [31:0] resp_hi, resp_lo;
   logic [1:0]  resp_kind, resp_target;
   logic [7:0]  resp_syndrome;

   int n_checks = 0, n_fail = 0;
   logic [63:0] m_cnt, m_off;

   always #2 clk = ~clk;

   vcnt_read_unit i_vcnt_read_unit (.*);

   always @(posedge clk) begin
      if (!rst_n) begin m_cnt <= '0; m_off <= '0; end
      else begin
         if (cnt_en) m_cnt <= m_cnt + 64'd1;
         if (off_wr) m_off <= off_data;
      end
   end

   typedef struct packed {
      logic [1:0] lvl;
      logic l1n, l2n, hp, he, e2h, tge, enw, enn, hen, tvct;
      logic [1:0] kind, tgt;
      logic [7:0] syn;
      logic sub;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VEC [NV] = '{
      '{2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 2'd1,2'd1,8'h04,1'b0}, // R3 to L1
      '{2'd0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 2'd1,2'd2,8'h04,1'b0}, // R3 to L2
      '{2'd0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 2'd0,2'd0,8'h00,1'b1}, // R7 sub
      '{2'd0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 2'd1,2'd2,8'h04,1'b0}, // R4 wide L2
      '{2'd0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 2'd2,2'd2,8'h00,1'b0}, // R4 hyp trap
      '{2'd0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 2'd3,2'd0,8'h00,1'b0}, // R4 undef
      '{2'd0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 2'd1,2'd2,8'h04,1'b0}, // R5 host trap
      '{2'd0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1, 2'd0,2'd0,8'h00,1'b0}, // R7 host raw
      '{2'd1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1, 2'd1,2'd2,8'h04,1'b0}, // R6 level 1
      '{2'd0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1, 2'd1,2'd2,8'h04,1'b0}, // R6 level 0
      '{2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0,8'h00,1'b0}, // R7 no hyp raw
      '{2'd1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 2'd0,2'd0,8'h00,1'b1}, // R7 hyp off sub
      '{2'd2,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 2'd0,2'd0,8'h00,1'b1}, // R8 level 2
      '{2'd3,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0,8'h00,1'b0}, // R8 L3 raw
      '{2'd3,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0,8'h00,1'b1}, // R8 L3 sub
      '{2'd0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 2'd0,2'd0,8'h00,1'b1}  // R7 narrow sub
   };

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic apply(input vec_t v);
      {req_level, l1_narrow, l2_narrow, hyp_present, hyp_enabled, host_e2h, trap_gen,
       l1_en_wide, l1_en_narrow, l2_host_en, l2_trap_lo} =
      {v.lvl, v.l1n, v.l2n, v.hp, v.he, v.e2h, v.tge, v.enw, v.enn, v.hen, v.tvct};
   endtask

   // Issue one read at a negedge; returns the count and offset seen at acceptance.
   task automatic do_read(output logic [63:0] cnt_at, output logic [63:0] off_at);
      check(req_ready === 1'b1, "R9 ready before request", {63'd0, req_ready}, 64'd1);
      req_valid = 1'b1;
      cnt_at = m_cnt;
      off_at = m_off;
      @(negedge clk);
      req_valid = 1'b0;
      check(resp_valid === 1'b1, "R9 response one cycle later", {63'd0, resp_valid}, 64'd1);
   endtask

   task automatic check_resp(input vec_t v, input logic [63:0] c, input logic [63:0] o,
                             input string tag);
      logic [63:0] exp;
      exp = (v.kind != 2'd0) ? 64'd0 : (v.sub ? c - o : c);
      check(resp_kind === v.kind, {tag, " kind"}, {62'd0, resp_kind}, {62'd0, v.kind});
      check(resp_target === v.tgt, {tag, " target"}, {62'd0, resp_target}, {62'd0, v.tgt});
      check(resp_syndrome === v.syn, {tag, " syndrome"}, {56'd0, resp_syndrome}, {56'd0, v.syn});
      check({resp_hi, resp_lo} === exp, {tag, " R1 R2 value"}, {resp_hi, resp_lo}, exp);
   endtask

   initial begin
      #(200000 * 4);
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [63:0] c, o, c2, o2;
      vec_t v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R11 reset state: count and offset zero, no response pending
      check(resp_valid === 1'b0, "R11 reset no response", {63'd0, resp_valid}, 64'd0);
      v = VEC[12];                       // level 2 read, subtracts offset
      apply(v);
      do_read(c, o);
      check({resp_hi, resp_lo} === 64'd0, "R11 reset count minus offset", {resp_hi, resp_lo}, 64'd0);
      @(negedge clk);
      check(resp_valid === 1'b0, "R9 response taken", {63'd0, resp_valid}, 64'd0);

      // load an offset larger than the count so results wrap (R1), run the counter
      off_wr = 1'b1; off_data = 64'h0000_0003_0000_0010;
      cnt_en = 1'b1;
      @(negedge clk);
      off_wr = 1'b0;
      repeat (5) @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         apply(VEC[i]);
         do_read(c, o);
         check_resp(VEC[i], c, o, $sformatf("vector %0d", i));
         @(negedge clk);
      end

      // R11 count holds with cnt_en low
      cnt_en = 1'b0;
      apply(VEC[13]);
      do_read(c, o);
      check({resp_hi, resp_lo} === c, "R11 raw count", {resp_hi, resp_lo}, c);
      repeat (3) @(negedge clk);
      do_read(c2, o2);
      check({resp_hi, resp_lo} === c, "R11 count held while disabled", {resp_hi, resp_lo}, c);
      @(negedge clk);

      // R9 / R10 back-pressure: value captured at acceptance, held while not taken
      cnt_en = 1'b1;
      resp_ready = 1'b0;
      apply(VEC[14]);
      do_read(c, o);
      repeat (3) @(negedge clk);
      check(resp_valid === 1'b1, "R9 held while not ready", {63'd0, resp_valid}, 64'd1);
      check(req_ready === 1'b0, "R9 no second request", {63'd0, req_ready}, 64'd0);
      check({resp_hi, resp_lo} === c - o, "R10 acceptance-cycle value", {resp_hi, resp_lo}, c - o);
      resp_ready = 1'b1;
      @(negedge clk);

      // R9 order: back-to-back reads give increasing values
      do_read(c, o);
      check({resp_hi, resp_lo} === c - o, "R9 first read", {resp_hi, resp_lo}, c - o);
      @(negedge clk);
      do_read(c2, o2);
      check({resp_hi, resp_lo} === c2 - o2, "R9 second read", {resp_hi, resp_lo}, c2 - o2);
      check(c2 - c == 64'd2, "R9 reads in order", c2 - c, 64'd2);
      @(negedge clk);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule